// File: doc/BRIEF.md
# Ganged Port Power Controller

This block drives the one power-switch enable that feeds every downstream port of a hub. The host turns ports on and off one at a time with set and clear strobes that carry a port index. The block keeps one request bit per port and holds the shared enable high while any of those bits is set.

A single active-low overcurrent pin covers all ports. It is synchronized, and its entry forces the shared enable off at once and discards every port request. Entry also sets a sticky change bit that the host acknowledges with its own strobe.

A status lamp output is lit while the hub is enumerated and not suspended. Overcurrent entry switches the lamp into a blink mode with a parameterized rate. Blinking ends only when the host sends a clear-power request or the hub is enumerated again.

Top module: `gpp_ganged_power_ctrl`

## Requirements
- R1: After reset `pwr_en`, `oc_status` and `oc_change` are 0 and the lamp is not blinking, so `led` equals `enumerated & ~suspend`.
- R2: `pwr_en` can go from 0 to 1 only on the clock edge that samples `set_pwr_stb` high; a set strobe for index `port_sel` (0-based, 0 to NUM_PORTS-1) with no active fault raises `pwr_en` after that edge.
- R3: A clear strobe removes only the request of port `port_sel`. `pwr_en` stays high while any requested port remains, and falls after the edge that clears the last one. When set and clear are strobed in the same cycle, the clear wins for the shared index.
- R4: A low level on `oc_n` means overcurrent. `oc_status` follows the inverted pin through a two-stage synchronizer, so it changes after the second clock edge that samples the new pin level.
- R5: On the edge after `oc_status` rises, `pwr_en` falls and all port requests are discarded. Set strobes are ignored while `oc_status` is 1, and power stays off after the fault clears until a new set strobe arrives.
- R6: `oc_change` goes to 1 on the same edge that R5 removes power and holds until `oc_chg_clr` is sampled high. An overcurrent entry in the same cycle as `oc_chg_clr` leaves the bit at 1.
- R7: Outside blink mode, `led` equals `enumerated & ~suspend`, combinationally.
- R8: Overcurrent entry starts blink mode on the same edge as R6. In blink mode `led` is 1 for HALF cycles, then 0 for HALF cycles, and so on, where HALF = CLK_HZ / (2*BLINK_HZ).
- R9: Blink mode ends on the edge that samples a clear-power strobe (any index) or a rising `enumerated`. An overcurrent entry on that same edge keeps blink mode active and restarts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_pwr_stb | input | 1 | Host request: power on port `port_sel` |
| clr_pwr_stb | input | 1 | Host request: power off port `port_sel` |
| port_sel | input | $clog2(NUM_PORTS) | 0-based port index for both strobes |
| oc_n | input | 1 | Global overcurrent pin, low = fault |
| enumerated | input | 1 | Hub has been enumerated |
| suspend | input | 1 | Hub is suspended |
| oc_chg_clr | input | 1 | Host acknowledge of the overcurrent change bit |
| pwr_en | output | 1 | Ganged port power-switch enable |
| oc_status | output | 1 | Overcurrent indicator |
| oc_change | output | 1 | Overcurrent change bit |
| led | output | 1 | Status lamp drive |

## Verification
Overcurrent entry can fall in the same cycle as either of two host strobes. One is a clear-power strobe, which would end blink mode. The other is a change-bit acknowledge, which would clear `oc_change`. The bench times a pin fall so that the synchronized entry edge samples both strobes high. It then checks that the lamp is blinking and lit, that `oc_change` is 1 and that `pwr_en` is 0. Random traffic also lets these overlaps and set/clear collisions happen by chance, and a bench model that tracks the requirements judges every cycle.

// File: rtl/gpp_pkg.sv
package gpp_pkg;

  typedef enum logic {
    LAMP_STEADY = 1'b0,
    LAMP_BLINK  = 1'b1
  } lamp_mode_e;

  // Cycles per half blink period, never below one.
  function automatic int unsigned blink_half_cycles(input int unsigned clk_hz,
                                                    input int unsigned blink_hz);
    int unsigned half;
    half = clk_hz / (2 * blink_hz);
    return (half < 1) ? 1 : half;
  endfunction

  // Lamp level chosen from the mode, the blink phase and the hub state.
  function automatic logic lamp_level(input lamp_mode_e mode, input logic phase,
                                      input logic enum_f, input logic susp_f);
    return (mode == LAMP_BLINK) ? phase : (enum_f & ~susp_f);
  endfunction

endpackage

// File: rtl/gpp_oc_monitor.sv
module gpp_oc_monitor #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_n,
  input  logic chg_clr,
  output logic oc_active,
  output logic oc_entry,
  output logic oc_change
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   active_prev;

  // Synchronizer chain, idle level is high (no fault).
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= oc_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign oc_active = ~sync_q[SYNC_STAGES-1];
  assign oc_entry  = oc_active & ~active_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_prev <= 1'b0;
      oc_change   <= 1'b0;
    end else begin
      active_prev <= oc_active;
      if (oc_entry)     oc_change <= 1'b1;
      else if (chg_clr) oc_change <= 1'b0;
    end
  end

  AST_CHG_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    oc_entry |=> oc_change); // R6
  AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_change && !chg_clr) |=> oc_change); // R6
  AST_ENTRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    oc_entry |=> !oc_entry); // R4

endmodule

// File: rtl/gpp_power_mask.sv
module gpp_power_mask #(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned IDX_W = (NUM_PORTS < 2) ? 1 : $clog2(NUM_PORTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [IDX_W-1:0] sel,
  input  logic             oc_active,
  output logic             pwr_en
);

  logic [NUM_PORTS-1:0] req_q;

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      logic hit;
      assign hit = (sel == IDX_W'(p));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               req_q[p] <= 1'b0;
        else if (oc_active)       req_q[p] <= 1'b0;
        else if (clr_stb && hit)  req_q[p] <= 1'b0;
        else if (set_stb && hit)  req_q[p] <= 1'b1;
      end
    end
  endgenerate

  assign pwr_en = |req_q;

  AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && !set_stb) |=> !pwr_en); // R2
  AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && !oc_active && !clr_stb) |=> pwr_en); // R3
  AST_FAULT_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
    oc_active |=> !pwr_en); // R5

endmodule

// File: rtl/gpp_status_lamp.sv
module gpp_status_lamp
  import gpp_pkg::*;
#(
  parameter int unsigned HALF = 4,
  localparam int unsigned CNT_W = (HALF < 2) ? 1 : $clog2(HALF)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_entry,
  input  logic clr_stb,
  input  logic enumerated,
  input  logic suspend,
  output logic led
);

  lamp_mode_e       mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic             enum_prev;
  logic             enum_rise;
  logic             blinking;
  logic             exit_req;
  logic             half_done;

  assign enum_rise = enumerated & ~enum_prev;
  assign blinking  = (mode_q == LAMP_BLINK);
  assign exit_req  = blinking & (clr_stb | enum_rise);
  assign half_done = (cnt_q == CNT_W'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enum_prev <= 1'b0;
      mode_q    <= LAMP_STEADY;
      cnt_q     <= '0;
      phase_q   <= 1'b0;
    end else begin
      enum_prev <= enumerated;
      if (oc_entry) begin
        mode_q  <= LAMP_BLINK;
        cnt_q   <= '0;
        phase_q <= 1'b1;
      end else if (exit_req) begin
        mode_q  <= LAMP_STEADY;
        cnt_q   <= '0;
      end else if (blinking) begin
        if (half_done) begin
          cnt_q   <= '0;
          phase_q <= ~phase_q;
        end else begin
          cnt_q   <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign led = lamp_level(mode_q, phase_q, enumerated, suspend);

  AST_BLINK_START: assert property (@(posedge clk) disable iff (!rst_n)
    oc_entry |=> (blinking && led)); // R8
  AST_BLINK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req && !oc_entry) |=> !blinking); // R9
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(HALF - 1)); // R8
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (blinking && !half_done && !oc_entry && !exit_req) |=> $stable(phase_q)); // R8

endmodule

// File: rtl/gpp_ganged_power_ctrl.sv
module gpp_ganged_power_ctrl #(
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CLK_HZ      = 12_000_000,
  parameter int unsigned BLINK_HZ    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         set_pwr_stb,
  input  logic                         clr_pwr_stb,
  input  logic [$clog2(NUM_PORTS)-1:0] port_sel,
  input  logic                         oc_n,
  input  logic                         enumerated,
  input  logic                         suspend,
  input  logic                         oc_chg_clr,
  output logic                         pwr_en,
  output logic                         oc_status,
  output logic                         oc_change,
  output logic                         led
);

  localparam int unsigned HALF = gpp_pkg::blink_half_cycles(CLK_HZ, BLINK_HZ);

  logic oc_active;
  logic oc_entry;

  gpp_oc_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_oc (
    .clk       (clk),
    .rst_n     (rst_n),
    .oc_n      (oc_n),
    .chg_clr   (oc_chg_clr),
    .oc_active (oc_active),
    .oc_entry  (oc_entry),
    .oc_change (oc_change)
  );

  gpp_power_mask #(.NUM_PORTS(NUM_PORTS)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_stb   (set_pwr_stb),
    .clr_stb   (clr_pwr_stb),
    .sel       (port_sel),
    .oc_active (oc_active),
    .pwr_en    (pwr_en)
  );

  gpp_status_lamp #(.HALF(HALF)) u_lamp (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_entry   (oc_entry),
    .clr_stb    (clr_pwr_stb),
    .enumerated (enumerated),
    .suspend    (suspend),
    .led        (led)
  );

  assign oc_status = oc_active;

  AST_CHANGE_WITH_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_change) |-> !pwr_en); // R6

endmodule

// File: tb/tb_gpp_ganged_power_ctrl.sv
`timescale 1ns/1ps
module tb_gpp_ganged_power_ctrl;

  localparam int NP   = 4;
  localparam int HALF = 10; // 400 / (2*20)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_pwr_stb = 0, clr_pwr_stb = 0, oc_n = 1, enumerated = 0, suspend = 0, oc_chg_clr = 0;
  logic [1:0] port_sel = '0;
  logic pwr_en, oc_status, oc_change, led;

  always #2.5 clk = ~clk;

  gpp_ganged_power_ctrl #(.NUM_PORTS(NP), .CLK_HZ(400), .BLINK_HZ(20)) dut (
    .clk(clk), .rst_n(rst_n), .set_pwr_stb(set_pwr_stb), .clr_pwr_stb(clr_pwr_stb),
    .port_sel(port_sel), .oc_n(oc_n), .enumerated(enumerated), .suspend(suspend),
    .oc_chg_clr(oc_chg_clr), .pwr_en(pwr_en), .oc_status(oc_status),
    .oc_change(oc_change), .led(led));

  int tests = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  logic       m_s1, m_s2, m_prev, m_chg, m_blink, m_phase, m_enp;
  logic [NP-1:0] m_req;
  int         m_cnt;
  logic       t_act, t_entry, t_rise;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_prev = 0; m_chg = 0; m_blink = 0; m_phase = 0;
      m_enp = 0; m_req = '0; m_cnt = 0;
    end else begin
      t_act   = ~m_s2;
      t_entry = t_act & ~m_prev;
      t_rise  = enumerated & ~m_enp;
      m_s2 = m_s1; m_s1 = oc_n; m_prev = t_act; m_enp = enumerated;
      if (t_act) m_req = '0;
      else if (clr_pwr_stb) m_req[port_sel] = 1'b0;
      else if (set_pwr_stb) m_req[port_sel] = 1'b1;
      if (t_entry) m_chg = 1; else if (oc_chg_clr) m_chg = 0;
      if (t_entry) begin m_blink = 1; m_cnt = 0; m_phase = 1; end
      else if (m_blink && (clr_pwr_stb || t_rise)) begin m_blink = 0; m_cnt = 0; end
      else if (m_blink) begin
        if (m_cnt == HALF - 1) begin m_cnt = 0; m_phase = ~m_phase; end
        else m_cnt++;
      end
    end
  end

  bit cmp_en = 0;
  always @(negedge clk) if (cmp_en) begin
    chk("R2/R3/R5 model pwr_en", pwr_en, |m_req);
    chk("R4 model oc_status", oc_status, ~m_s2);
    chk("R6 model oc_change", oc_change, m_chg);
    chk("R7/R8/R9 model led", led, m_blink ? m_phase : (enumerated & ~suspend));
  end

  task automatic nxt(); @(negedge clk); endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C01));
    repeat (4) nxt();
    #1 rst_n = 1;
    cmp_en = 1;
    nxt();
    chk("R1 pwr_en", pwr_en, 0); chk("R1 oc_status", oc_status, 0);
    chk("R1 oc_change", oc_change, 0); chk("R1 led", led, 0);

    // Per-port requests
    #1 set_pwr_stb = 1; port_sel = 2; nxt(); chk("R2 set raises", pwr_en, 1);
    #1 port_sel = 0; nxt();
    #1 set_pwr_stb = 0; clr_pwr_stb = 1; port_sel = 2; nxt(); chk("R3 partial clear", pwr_en, 1);
    #1 port_sel = 0; nxt(); chk("R3 last clear", pwr_en, 0);
    #1 set_pwr_stb = 1; clr_pwr_stb = 1; port_sel = 1; nxt(); chk("R3 clear wins", pwr_en, 0);
    #1 set_pwr_stb = 0; clr_pwr_stb = 0;

    // Steady lamp
    enumerated = 1; nxt(); chk("R7 lamp on", led, 1);
    #1 suspend = 1; nxt(); chk("R7 lamp suspended", led, 0);
    #1 suspend = 0;

    // Overcurrent
    set_pwr_stb = 1; port_sel = 3; nxt();
    #1 set_pwr_stb = 0; oc_n = 0; nxt(); chk("R4 one edge", oc_status, 0);
    nxt(); chk("R4 two edges", oc_status, 1); chk("R5 not yet cut", pwr_en, 1);
    nxt(); chk("R5 power cut", pwr_en, 0); chk("R6 change set", oc_change, 1); chk("R8 blink on", led, 1);
    for (int i = 1; i < HALF; i++) begin nxt(); chk("R8 high half", led, 1); end
    nxt(); chk("R8 low half", led, 0);
    #1 set_pwr_stb = 1; port_sel = 0; nxt(); chk("R5 set ignored", pwr_en, 0);
    #1 set_pwr_stb = 0; oc_chg_clr = 1; nxt(); chk("R6 acknowledge", oc_change, 0);
    #1 oc_chg_clr = 0; oc_n = 1; nxt(); nxt(); chk("R4 fault gone", oc_status, 0);
    chk("R5 stays off", pwr_en, 0);
    #1 clr_pwr_stb = 1; port_sel = 3; nxt();
    #1 clr_pwr_stb = 0;
    for (int i = 0; i < HALF + 2; i++) begin nxt(); chk("R9 clear ends blink", led, 1); end

    // Entry in the same cycle as a clear strobe and an acknowledge
    #1 oc_n = 0; nxt(); nxt();
    #1 clr_pwr_stb = 1; oc_chg_clr = 1; port_sel = 1; nxt();
    chk("R9 entry beats clear", led, 1); chk("R6 entry beats ack", oc_change, 1);
    #1 clr_pwr_stb = 0; oc_chg_clr = 0;
    for (int i = 1; i < HALF; i++) nxt();
    nxt(); chk("R9 still blinking", led, 0);
    #1 enumerated = 0; nxt();
    #1 enumerated = 1; nxt();
    for (int i = 0; i < HALF + 2; i++) begin nxt(); chk("R9 re-enum ends blink", led, 1); end
    #1 oc_n = 1;

    // Random traffic
    for (int c = 0; c < 8000; c++) begin
      nxt();
      #1;
      set_pwr_stb = ($urandom_range(0, 6) == 0);
      clr_pwr_stb = ($urandom_range(0, 9) == 0);
      port_sel    = 2'($urandom_range(0, NP - 1));
      oc_chg_clr  = ($urandom_range(0, 24) == 0);
      if ($urandom_range(0, 149) == 0) oc_n = ~oc_n;
      if ($urandom_range(0, 119) == 0) enumerated = ~enumerated;
      if ($urandom_range(0, 119) == 0) suspend = ~suspend;
    end
    nxt();
    cmp_en = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule